// File: doc/BRIEF.md
# Abstract Register-Access Command Generator

This block sits in a debug module between the debugger-facing register file and a halted hart. When the debugger writes an access-register command, the block checks the command. If the command is valid, it writes two 32-bit RISC-V instructions into a small abstract-instruction buffer. It then raises a one-cycle go pulse for the selected hart and holds busy until the hart reports that it has parked again.

The first instruction moves a general-purpose register to or from the data area. The data area starts at byte address `DATA_BASE` (default 0x380), and the instruction addresses it with an absolute offset from x0. The second instruction either jumps forward into the program buffer or traps back with ebreak. The buffer sits directly below the program buffer, and the program buffer sits directly below the data area.

Reads of data words and program-buffer words can re-launch the last command written, through per-index auto-execute masks. A data read while busy records a busy-conflict error.

Top module: `abscmd_gen`

## Requirements
- R1: After reset, busy and goSet are 0, cmdErr is 0 (none), and both buffer words hold ebreak (0x00100073).
- R2: The command word must have bits [31:24] equal to zero (access-register type), and reserved bits 23 and 19 must also be zero. Otherwise the command is rejected with cmdErr code 2 (not supported), and neither busy nor goSet rises.
- R3: A type-valid command is rejected with cmdErr code 4 (halt/resume) when bit `hartSel` of `hartHalted` is 0.
- R4: With the transfer bit (bit 17) set, the command is rejected with code 2 in either of two cases. The first is a register number (bits [15:0]) outside 0x1000 to 0x101F. The second is a size code (bits [22:20]) other than 2 or 3.
- R5: An accepted command raises busy and a one-cycle goSet at the same clock edge, with goHart equal to hartSel.
- R6: With transfer set, the first word uses GPR number = regno − 0x1000 and immediate `DATA_BASE` off x0. When the write bit (bit 16) is 1, the word is a load into the GPR. When it is 0, the word is a store from the GPR. Size 2 selects the word form (funct3 2) and size 3 selects the doubleword form (funct3 3).
- R7: Without transfer, the first word is a store of x0 to the data area (0x38002023 by default).
- R8: With postexec (bit 18) set, the second word is a JAL x0 to the start of the program buffer. The offset is relative to the second word's address, which gives 0x0040006F. Otherwise the second word is ebreak.
- R9: Busy stays set until a hartParked pulse. While busy, no command or auto-execute is launched and the buffer words do not change.
- R10: While busy, any data read, any command write, or any auto-execute trigger sets cmdErr to code 1 (busy).
- R11: Reading data word i while autoDataMask[i] is 1 re-runs the last command written while not busy.
- R12: Reading program-buffer word i while autoProgMask[i] is 1 re-runs that same command.
- R13: cmdErr is sticky. A new error is recorded only when cmdErr holds 0. errClr returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdWrite | input | 1 | Debugger writes the command word this cycle |
| cmdIn | input | 32 | Command word |
| hartHalted | input | NUM_HARTS | Per-hart halted status |
| hartSel | input | HART_W | Selected hart |
| dataRead | input | 1 | Debugger reads a data word this cycle |
| dataIdx | input | DIDX_W | Index of the data word read |
| progRead | input | 1 | Debugger reads a program-buffer word this cycle |
| progIdx | input | PIDX_W | Index of the program-buffer word read |
| autoDataMask | input | DATA_WORDS | Auto-execute enables for data reads |
| autoProgMask | input | PROG_WORDS | Auto-execute enables for program-buffer reads |
| hartParked | input | 1 | Selected hart has finished the buffer and parked |
| errClr | input | 1 | Clears the command error |
| busy | output | 1 | A command is executing |
| cmdErr | output | 3 | Command error code |
| goSet | output | 1 | One-cycle request to set the go flag |
| goHart | output | HART_W | Hart whose go flag is set |
| instrWord0 | output | 32 | First buffer instruction |
| instrWord1 | output | 32 | Second buffer instruction |

## Verification
All block state is visible at the ports one clock after the edge that changes it. A wrong busy or go-pulse state therefore shows up at once, as a missing or doubled goSet or a busy that never drops. A wrong decode shows up in the buffer words or the error code in the cycle after the command. A stale stored command only surfaces when an auto-execute read fires, so the reference model compares every output on every cycle through mixed sequences of writes, auto reads and conflicts.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_BUSY       = 3'd1,
    ERR_NOTSUP     = 3'd2,
    ERR_EXCEPT     = 3'd3,
    ERR_HALTRESUME = 3'd4
  } cmdErr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       xfer;
    logic       wr;
    logic       wide;
    logic       post;
    logic [4:0] gpr;
  } bufStrobe_t;

  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;
  localparam logic [6:0]  OPC_LOAD    = 7'b0000011;
  localparam logic [6:0]  OPC_STORE   = 7'b0100011;
  localparam logic [6:0]  OPC_JAL     = 7'b1101111;

  function automatic logic [31:0] mkLoad(input logic [4:0] rd, input logic wide,
                                         input logic [11:0] imm);
    return {imm, 5'd0, wide ? 3'b011 : 3'b010, rd, OPC_LOAD};
  endfunction

  function automatic logic [31:0] mkStore(input logic [4:0] rs2, input logic wide,
                                          input logic [11:0] imm);
    return {imm[11:5], rs2, 5'd0, wide ? 3'b011 : 3'b010, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [31:0] mkJal(input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd0, OPC_JAL};
  endfunction

endpackage

// File: rtl/abscmd_ctrl.sv
module abscmd_ctrl
  import abscmd_pkg::*;
#(
  parameter int NUM_HARTS  = 4,
  parameter int DATA_WORDS = 8,
  parameter int PROG_WORDS = 8,
  localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
  localparam int DIDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
  localparam int PIDX_W = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdWrite,
  input  logic [31:0]           cmdIn,
  input  logic [NUM_HARTS-1:0]  hartHalted,
  input  logic [HART_W-1:0]     hartSel,
  input  logic                  dataRead,
  input  logic [DIDX_W-1:0]     dataIdx,
  input  logic                  progRead,
  input  logic [PIDX_W-1:0]     progIdx,
  input  logic [DATA_WORDS-1:0] autoDataMask,
  input  logic [PROG_WORDS-1:0] autoProgMask,
  input  logic                  hartParked,
  input  logic                  errClr,
  output logic                  busy,
  output cmdErr_e               cmdErr,
  output logic                  goSet,
  output logic [HART_W-1:0]     goHart,
  output bufStrobe_t            strobe
);

  logic [31:0] cmdReg;
  logic [31:0] activeCmd;
  logic        autoHit;
  logic        trig;
  logic        launch;
  logic        conflict;
  logic        badType;
  logic [2:0]  sizeCode;
  cmdErr_e     verdict;
  cmdErr_e     newErr;

  assign autoHit   = (dataRead && autoDataMask[dataIdx]) ||
                     (progRead && autoProgMask[progIdx]);
  assign trig      = cmdWrite || autoHit;
  assign activeCmd = cmdWrite ? cmdIn : cmdReg;
  assign sizeCode  = activeCmd[22:20];
  assign badType   = (activeCmd[31:23] != 9'd0) || activeCmd[19];

  always_comb begin
    verdict = ERR_NONE;
    if (badType) begin
      verdict = ERR_NOTSUP;
    end else if (!hartHalted[hartSel]) begin
      verdict = ERR_HALTRESUME;
    end else if (activeCmd[17]) begin
      if (activeCmd[15:5] != 11'h080) begin
        verdict = ERR_NOTSUP;
      end else if (sizeCode != 3'd2 && sizeCode != 3'd3) begin
        verdict = ERR_NOTSUP;
      end
    end
  end

  assign conflict = busy && (trig || dataRead);
  assign launch   = trig && !busy && (verdict == ERR_NONE);

  always_comb begin
    newErr = ERR_NONE;
    if (conflict) begin
      newErr = ERR_BUSY;
    end else if (trig && !busy) begin
      newErr = verdict;
    end
  end

  always_comb begin
    strobe.load = launch;
    strobe.xfer = activeCmd[17];
    strobe.wr   = activeCmd[16];
    strobe.wide = (sizeCode == 3'd3);
    strobe.post = activeCmd[18];
    strobe.gpr  = activeCmd[4:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      goSet  <= 1'b0;
      goHart <= '0;
      cmdErr <= ERR_NONE;
      cmdReg <= '0;
    end else begin
      goSet <= launch;
      if (launch) begin
        goHart <= hartSel;
      end
      if (launch) begin
        busy <= 1'b1;
      end else if (hartParked) begin
        busy <= 1'b0;
      end
      if (cmdWrite && !busy) begin
        cmdReg <= cmdIn;
      end
      if (newErr != ERR_NONE && cmdErr == ERR_NONE) begin
        cmdErr <= newErr;
      end else if (errClr) begin
        cmdErr <= ERR_NONE;
      end
    end
  end

  // R5: the go pulse coincides with busy rising
  p_go_with_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    goSet |-> $rose(busy));

  // R5: go is a single-cycle pulse
  p_go_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    goSet |=> !goSet);

  // R9: busy holds until the hart parks
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !hartParked) |=> busy);

  // R10: a data read during busy flags a conflict
  p_busy_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataRead && cmdErr == ERR_NONE) |=> (cmdErr == ERR_BUSY));

  // R3: an unhalted hart never gets a go pulse
  p_no_go_unhalted_r3: assert property (@(posedge clk) disable iff (!rstN)
    (trig && !busy && !hartHalted[hartSel]) |=> !goSet);

  // R2: a wrong command type raises neither busy nor go
  p_badtype_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trig && !busy && badType) |=> (!busy && !goSet));

endmodule

// File: rtl/abscmd_datapath.sv
module abscmd_datapath
  import abscmd_pkg::*;
#(
  parameter int DATA_BASE  = 'h380,
  parameter int PROG_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  bufStrobe_t  strobe,
  output logic [31:0] instrWord0,
  output logic [31:0] instrWord1
);

  localparam int PROG_BASE = DATA_BASE - 4 * PROG_WORDS;
  localparam int ABS_BASE  = PROG_BASE - 8;
  localparam int JUMP_OFF  = PROG_BASE - (ABS_BASE + 4);
  localparam logic [20:0] JUMP_IMM = 21'(JUMP_OFF);
  localparam logic [11:0] DATA_IMM = 12'(DATA_BASE);

  logic [31:0] nextWord0;
  logic [31:0] nextWord1;

  always_comb begin
    if (!strobe.xfer) begin
      nextWord0 = mkStore(5'd0, 1'b0, DATA_IMM);
    end else if (strobe.wr) begin
      nextWord0 = mkLoad(strobe.gpr, strobe.wide, DATA_IMM);
    end else begin
      nextWord0 = mkStore(strobe.gpr, strobe.wide, DATA_IMM);
    end
    nextWord1 = strobe.post ? mkJal(JUMP_IMM) : INSN_EBREAK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrWord0 <= INSN_EBREAK;
      instrWord1 <= INSN_EBREAK;
    end else if (strobe.load) begin
      instrWord0 <= nextWord0;
      instrWord1 <= nextWord1;
    end
  end

  // R9: buffer changes only on a launch
  p_buf_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(instrWord0) && $stable(instrWord1)));

  // R8: a launch without postexec leaves ebreak in the second word
  p_word1_ebreak_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.post) |=> (instrWord1 == INSN_EBREAK));

endmodule

// File: rtl/abscmd_gen.sv
module abscmd_gen
  import abscmd_pkg::*;
#(
  parameter int NUM_HARTS  = 4,
  parameter int DATA_WORDS = 8,
  parameter int PROG_WORDS = 8,
  parameter int DATA_BASE  = 'h380,
  localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
  localparam int DIDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
  localparam int PIDX_W = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdWrite,
  input  logic [31:0]           cmdIn,
  input  logic [NUM_HARTS-1:0]  hartHalted,
  input  logic [HART_W-1:0]     hartSel,
  input  logic                  dataRead,
  input  logic [DIDX_W-1:0]     dataIdx,
  input  logic                  progRead,
  input  logic [PIDX_W-1:0]     progIdx,
  input  logic [DATA_WORDS-1:0] autoDataMask,
  input  logic [PROG_WORDS-1:0] autoProgMask,
  input  logic                  hartParked,
  input  logic                  errClr,
  output logic                  busy,
  output logic [2:0]            cmdErr,
  output logic                  goSet,
  output logic [HART_W-1:0]     goHart,
  output logic [31:0]           instrWord0,
  output logic [31:0]           instrWord1
);

  bufStrobe_t strobe;
  cmdErr_e    errCode;

  abscmd_ctrl #(
    .NUM_HARTS (NUM_HARTS),
    .DATA_WORDS(DATA_WORDS),
    .PROG_WORDS(PROG_WORDS)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cmdWrite    (cmdWrite),
    .cmdIn       (cmdIn),
    .hartHalted  (hartHalted),
    .hartSel     (hartSel),
    .dataRead    (dataRead),
    .dataIdx     (dataIdx),
    .progRead    (progRead),
    .progIdx     (progIdx),
    .autoDataMask(autoDataMask),
    .autoProgMask(autoProgMask),
    .hartParked  (hartParked),
    .errClr      (errClr),
    .busy        (busy),
    .cmdErr      (errCode),
    .goSet       (goSet),
    .goHart      (goHart),
    .strobe      (strobe)
  );

  abscmd_datapath #(
    .DATA_BASE (DATA_BASE),
    .PROG_WORDS(PROG_WORDS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .instrWord0(instrWord0),
    .instrWord1(instrWord1)
  );

  assign cmdErr = errCode;

endmodule

// File: tb/abscmd_gen_tb.sv
module abscmd_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [31:0] cmdIn = '0;
  logic [3:0]  hartHalted = '0;
  logic [1:0]  hartSel = '0;
  logic        dataRead = 1'b0;
  logic [2:0]  dataIdx = '0;
  logic        progRead = 1'b0;
  logic [2:0]  progIdx = '0;
  logic [7:0]  autoDataMask = '0;
  logic [7:0]  autoProgMask = '0;
  logic        hartParked = 1'b0;
  logic        errClr = 1'b0;
  logic        busy;
  logic [2:0]  cmdErr;
  logic        goSet;
  logic [1:0]  goHart;
  logic [31:0] instrWord0;
  logic [31:0] instrWord1;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit modelOn = 0;

  // reference model state
  bit          mBusy;
  int          mErr;
  bit          mGo;
  int          mGoHart;
  logic [31:0] mW0, mW1, mCmd;

  always #10 clk = ~clk;

  abscmd_gen dut_i (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdIn(cmdIn),
    .hartHalted(hartHalted), .hartSel(hartSel), .dataRead(dataRead),
    .dataIdx(dataIdx), .progRead(progRead), .progIdx(progIdx),
    .autoDataMask(autoDataMask), .autoProgMask(autoProgMask),
    .hartParked(hartParked), .errClr(errClr), .busy(busy), .cmdErr(cmdErr),
    .goSet(goSet), .goHart(goHart), .instrWord0(instrWord0), .instrWord1(instrWord1)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic int judge(input logic [31:0] c, input int sel);
    int regno = int'(c[15:0]);
    int sz = int'(c[22:20]);
    if (c[31:23] != 0 || c[19]) return 2;
    if (!hartHalted[sel]) return 4;
    if (c[17]) begin
      if (regno < 'h1000 || regno > 'h101F) return 2;
      if (sz != 2 && sz != 3) return 2;
    end
    return 0;
  endfunction

  function automatic logic [31:0] word0Of(input logic [31:0] c);
    int rd = int'(c[15:0]) - 'h1000;
    int f3 = int'(c[22:20]);
    if (!c[17]) return 32'h3800_2023;
    if (c[16]) return 32'('h380 * (2**20) + f3 * (2**12) + rd * (2**7) + 3);
    return 32'(('h380 / 32) * (2**25) + rd * (2**20) + f3 * (2**12) + 'h23);
  endfunction

  function automatic logic [31:0] word1Of(input logic [31:0] c);
    // jump from second buffer word to program buffer start: offset +4
    if (c[18]) return 32'h0040_006F;
    return 32'h0010_0073;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mBusy = 0; mErr = 0; mGo = 0; mGoHart = 0;
      mW0 = 32'h0010_0073; mW1 = 32'h0010_0073; mCmd = '0;
    end else begin
      bit ah, tr, go;
      int ne;
      logic [31:0] c;
      ah = (dataRead && autoDataMask[dataIdx]) || (progRead && autoProgMask[progIdx]);
      tr = cmdWrite || ah;
      c = cmdWrite ? cmdIn : mCmd;
      ne = 0; go = 0;
      if (mBusy) begin
        if (tr || dataRead) ne = 1;
      end else if (tr) begin
        ne = judge(c, int'(hartSel));
        go = (ne == 0);
      end
      if (cmdWrite && !mBusy) mCmd = cmdIn;
      if (ne != 0 && mErr == 0) mErr = ne;
      else if (errClr) mErr = 0;
      if (go) begin
        mW0 = word0Of(c); mW1 = word1Of(c); mBusy = 1; mGoHart = int'(hartSel);
      end else if (hartParked) mBusy = 0;
      mGo = go;
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      check("R9 busy", busy, mBusy);
      check("R13 cmdErr", cmdErr, mErr);
      check("R5 goSet", goSet, mGo);
      if (mGo) check("R5 goHart", goHart, mGoHart);
      check("R6 word0", instrWord0, mW0);
      check("R8 word1", instrWord1, mW1);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sendCmd(input logic [31:0] c);
    cmdWrite = 1; cmdIn = c; tick(); cmdWrite = 0;
  endtask

  task automatic park();
    hartParked = 1; tick(); hartParked = 0;
  endtask

  task automatic clearErr();
    errClr = 1; tick(); errClr = 0;
  endtask

  task automatic readData(input int i);
    dataRead = 1; dataIdx = 3'(i); tick(); dataRead = 0;
  endtask

  task automatic readProg(input int i);
    progRead = 1; progIdx = 3'(i); tick(); progRead = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    check("R1 busy", busy, 0);
    check("R1 err", cmdErr, 0);
    check("R1 go", goSet, 0);
    check("R1 w0", instrWord0, 32'h0010_0073);
    check("R1 w1", instrWord1, 32'h0010_0073);
    rstN = 1; modelOn = 1;
    hartHalted = 4'b0101; hartSel = 0;
    tick();

    // R5/R6: read x5, 32-bit
    sendCmd((32'd2 << 20) | (32'd1 << 17) | 32'h1005);
    check("R5 go", goSet, 1);
    check("R5 busy", busy, 1);
    check("R6 sw x5", instrWord0, 32'h3850_2023);
    check("R8 ebreak", instrWord1, 32'h0010_0073);
    tick();
    check("R5 single pulse", goSet, 0);
    // R9/R10: command while busy
    sendCmd((32'd3 << 20) | (32'd1 << 17) | 32'h1007);
    check("R10 busy err", cmdErr, 1);
    check("R9 no relaunch", instrWord0, 32'h3850_2023);
    readData(2);
    check("R10 still busy", cmdErr, 1);
    park();
    check("R9 park", busy, 0);
    clearErr();
    check("R13 clear", cmdErr, 0);

    // R6/R8: write x10, 64-bit, postexec
    sendCmd((32'd3 << 20) | (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 16) | 32'h100A);
    check("R6 ld x10", instrWord0, 32'h3800_3503);
    check("R8 jal", instrWord1, 32'h0040_006F);
    park();
    // R7: no transfer
    sendCmd(32'd1 << 18);
    check("R7 sw x0", instrWord0, 32'h3800_2023);
    park();
    // R2: bad type
    sendCmd(32'h0100_0000);
    check("R2 notsup", cmdErr, 2);
    check("R2 no busy", busy, 0);
    clearErr();
    sendCmd(32'h0080_0000);
    check("R2 reserved", cmdErr, 2);
    clearErr();
    // R3: unhalted hart
    hartSel = 1;
    sendCmd((32'd2 << 20) | (32'd1 << 17) | 32'h1001);
    check("R3 haltresume", cmdErr, 4);
    check("R3 no go", goSet, 0);
    clearErr();
    hartSel = 2;
    sendCmd((32'd2 << 20) | (32'd1 << 17) | 32'h1001);
    check("R5 goHart", goHart, 2);
    park();
    // R4: bad regno and bad size
    sendCmd((32'd2 << 20) | (32'd1 << 17) | 32'h1020);
    check("R4 regno", cmdErr, 2);
    clearErr();
    sendCmd((32'd4 << 20) | (32'd1 << 17) | 32'h1001);
    check("R4 size", cmdErr, 2);
    // R13: sticky, a later halt error does not overwrite
    hartSel = 3;
    sendCmd(32'h0);
    check("R13 sticky", cmdErr, 2);
    clearErr();
    hartSel = 0;

    // R11: auto data
    sendCmd((32'd2 << 20) | (32'd1 << 17) | (32'd1 << 16) | 32'h1003);
    park();
    autoDataMask = 8'b0000_1000;
    readData(2);
    check("R11 masked off", goSet, 0);
    readData(3);
    check("R11 auto go", goSet, 1);
    check("R11 lw x3", instrWord0, 32'h3800_2183);
    readData(3);
    check("R10 auto while busy", cmdErr, 1);
    park();
    clearErr();
    // R12: auto progbuf
    autoProgMask = 8'b0000_0010;
    readProg(0);
    check("R12 masked off", busy, 0);
    readProg(1);
    check("R12 auto go", goSet, 1);
    park();
    repeat (3) tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule